// File: doc/BRIEF.md
# Negacyclic Polynomial Multiplier over Z_q

This block multiplies two polynomials whose coefficients lie in Z_q and whose products are taken modulo x^n + 1. With the default parameters n is 512 and q is 12289. The method is the number theoretic transform. The caller pulses `start`, which begins a load. It then presents one coefficient of each operand, lowest rank first, on every cycle in which `in_valid` is high. Each coefficient is weighted by a power of phi as it arrives. Phi is a primitive 2n-th root of unity, and omega = phi^2 is the transform root. Weighting turns the cyclic transform product into the negacyclic one.

Two transform engines then run the forward transforms of both weighted operands at the same time. The results are multiplied point-wise, with the 1/n factor of the inverse folded in. The first engine then runs a single inverse transform with omega^-1. On the way out, coefficient j is multiplied by phi^-j and `c(x)` streams out in rank order. A pulse on `done` closes the run.

All powers of phi, omega and their inverses come from one constant table of 2n entries. The table is computed at elaboration from a generator of the multiplicative group mod q. A single central controller steps through the phases: load with weighting, forward, point-wise, inverse, and output with unweighting.

Top module: `negacyc_mult`

## Requirements
- R1: `out_coef` carries the coefficients of a(x)·b(x) mod (x^n + 1, q). A term x^(n+k) contributes -1 times its value to rank k.
- R2: During loading, a coefficient pair is taken on every cycle with `in_valid` high and none otherwise. Pairs are taken in ascending rank from 0 to n-1, and each coefficient is weighted by phi^rank as it is taken. A pulse on `in_valid` outside the load phase changes nothing.
- R3: The result appears as c_0 … c_(n-1), in that order, on n consecutive cycles with `out_valid` high. Exactly n coefficients are produced per `start`.
- R4: Every output coefficient, and every value written into coefficient storage, lies in [0, q-1]. Input coefficients are assumed to lie in the same range.
- R5: `done` is high for exactly one cycle, and that cycle is the one right after the cycle carrying c_(n-1).
- R6: `start` is acted on only when the block is idle. A `start` pulse during any other phase is ignored.
- R7: The two forward transforms share the same cycles. With `in_valid` held high for the whole load, the first `out_valid` cycle follows the clock edge that samples `start` by exactly 2n + n·log2(n) + 1 edges.
- R8: While reset is held, and after it is released, `out_valid` and `done` are low until a run produces output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (ignored unless idle) |
| in_valid | input | 1 | Qualifies `a_coef` and `b_coef` during loading |
| a_coef | input | CW | Next coefficient of a(x) |
| b_coef | input | CW | Next coefficient of b(x) |
| out_valid | output | 1 | `out_coef` holds a result coefficient |
| out_coef | output | CW | Result coefficient, rank order |
| done | output | 1 | One-cycle pulse after the last result coefficient |

## Verification
The assertions assume that every coefficient offered while loading is already reduced below q, because the range checks on stored data rest on that. The stimulus draws operands with a modulo-q reduction and uses in-range values even for the junk it drives outside the load phase. The assertions also assume the caller waits for `done` before issuing the next real `start`. The bench observes this for every run it checks; its only early `start` pulses are deliberate and fall inside the forward-transform phase.

// File: rtl/ncm_pkg.sv
package ncm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_FWD, PH_PMUL, PH_INV, PH_OUT
  } phase_t;

  // Modular helpers on 32-bit operands; callers narrow the results.
  function automatic int unsigned mod_add(input int unsigned a, input int unsigned b,
                                          input int unsigned q);
    int unsigned s;
    s = a + b;
    return (s >= q) ? s - q : s;
  endfunction

  function automatic int unsigned mod_sub(input int unsigned a, input int unsigned b,
                                          input int unsigned q);
    return (a >= b) ? a - b : a + q - b;
  endfunction

  function automatic int unsigned mod_mul(input int unsigned a, input int unsigned b,
                                          input int unsigned q);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return 32'(p % 64'(q));
  endfunction

  function automatic int unsigned pow_mod(input int unsigned base, input int unsigned e,
                                          input int unsigned q);
    int unsigned r;
    int unsigned x;
    r = 1;
    x = base % q;
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r = mod_mul(r, x, q);
      x = mod_mul(x, x, q);
    end
    return r;
  endfunction

endpackage

// File: rtl/ncm_rom.sv
// Table of phi^k mod q for k = 0 .. 2n-1, computed at elaboration.
module ncm_rom #(
  parameter int unsigned N   = 512,
  parameter int unsigned Q   = 12289,
  parameter int unsigned PHI = 1,
  localparam int unsigned CW = $clog2(Q),
  localparam int unsigned AW = $clog2(2 * N)
) (
  input  logic [AW-1:0] addr,
  output logic [CW-1:0] val
);
  logic [CW-1:0] tbl [2*N];

  for (genvar k = 0; k < 2 * N; k++) begin : g_pow
    localparam int unsigned PV = ncm_pkg::pow_mod(PHI, 32'(k), Q);
    assign tbl[k] = CW'(PV);
  end

  assign val = tbl[addr];
endmodule

// File: rtl/ncm_engine.sv
// One transform engine: coefficient storage plus a butterfly that runs
// decimation-in-frequency (forward) or decimation-in-time (inverse).
module ncm_engine #(
  parameter int unsigned N = 512,
  parameter int unsigned Q = 12289,
  localparam int unsigned CW   = $clog2(Q),
  localparam int unsigned LOGN = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [LOGN-1:0] wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic            bf_en,
  input  logic            bf_inv,
  input  logic [LOGN-1:0] bf_i0,
  input  logic [LOGN-1:0] bf_i1,
  input  logic [CW-1:0]   bf_w,
  input  logic [LOGN-1:0] rd_addr,
  output logic [CW-1:0]   rd_data
);
  function automatic logic [CW-1:0] madd(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return CW'(ncm_pkg::mod_add(32'(a), 32'(b), Q));
  endfunction
  function automatic logic [CW-1:0] msub(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return CW'(ncm_pkg::mod_sub(32'(a), 32'(b), Q));
  endfunction
  function automatic logic [CW-1:0] mmul(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return CW'(ncm_pkg::mod_mul(32'(a), 32'(b), Q));
  endfunction

  logic [CW-1:0] mem [N];
  logic [CW-1:0] u, v, t, x0, x1;

  always_comb begin
    u = mem[bf_i0];
    v = mem[bf_i1];
    if (bf_inv) begin
      t  = mmul(v, bf_w);
      x0 = madd(u, t);
      x1 = msub(u, t);
    end else begin
      t  = msub(u, v);
      x0 = madd(u, v);
      x1 = mmul(t, bf_w);
    end
  end

  always_ff @(posedge clk) begin
    if (bf_en) begin
      mem[bf_i0] <= x0;
      mem[bf_i1] <= x1;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  p_bf_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bf_en |-> (32'(x0) < Q) && (32'(x1) < Q));
  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_data) < Q));
  p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bf_en && wr_en));
  p_pair_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bf_en |-> (bf_i1 > bf_i0));
endmodule

// File: rtl/ncm_ctrl.sv
// Central sequencer: phase FSM, element counter, butterfly index and
// twiddle exponent generation (exponents are in units of phi, mod 2n).
module ncm_ctrl #(
  parameter int unsigned N = 512,
  localparam int unsigned LOGN = $clog2(N),
  localparam int unsigned SW   = $clog2(LOGN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output ncm_pkg::phase_t   phase,
  output logic [LOGN-1:0]   cnt,
  output logic [LOGN-1:0]   bf_i0,
  output logic [LOGN-1:0]   bf_i1,
  output logic [LOGN:0]     tw_exp
);
  import ncm_pkg::*;

  localparam logic [LOGN-1:0] LAST_CNT = '1;
  localparam logic [LOGN-2:0] LAST_K   = '1;
  localparam logic [SW-1:0]   LAST_ST  = SW'(LOGN - 1);

  logic [SW-1:0]   stage;
  logic [LOGN-2:0] k;
  logic [SW-1:0]   lensh;
  logic [LOGN-1:0] kx, mask, j;
  logic [LOGN:0]   jw;
  logic            stage_end, xform_end;

  assign stage_end = (k == LAST_K);
  assign xform_end = stage_end && (stage == LAST_ST);

  always_comb begin
    lensh  = (phase == PH_INV) ? stage : (SW'(LOGN - 1) - stage);
    kx     = {1'b0, k};
    mask   = (LOGN'(1) << lensh) - LOGN'(1);
    j      = kx & mask;
    bf_i0  = ((kx >> lensh) << (lensh + SW'(1))) | j;
    bf_i1  = bf_i0 | (LOGN'(1) << lensh);
    jw     = {1'b0, j};
    if (phase == PH_INV) tw_exp = (LOGN+1)'(0) - (jw << (SW'(LOGN) - stage));
    else                 tw_exp = jw << (stage + SW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      stage <= '0;
      k     <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LOAD;
          cnt   <= '0;
        end
        PH_LOAD: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) begin
            phase <= PH_FWD;
            stage <= '0;
            k     <= '0;
          end
        end
        PH_FWD, PH_INV: begin
          k <= k + 1'b1;
          if (stage_end) stage <= stage + 1'b1;
          if (xform_end) begin
            phase <= (phase == PH_FWD) ? PH_PMUL : PH_OUT;
            stage <= '0;
            cnt   <= '0;
          end
        end
        PH_PMUL: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) begin
            phase <= PH_INV;
            stage <= '0;
            k     <= '0;
          end
        end
        PH_OUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_start_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && $past(phase) != PH_LOAD) |-> ($past(start) && $past(phase) == PH_IDLE));
  p_load_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && !in_valid) |=> $stable(cnt));
  p_fwd_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_FWD && phase != PH_FWD) |-> (phase == PH_PMUL));
  p_inv_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_INV && phase != PH_INV) |-> (phase == PH_OUT));
endmodule

// File: rtl/negacyc_mult.sv
module negacyc_mult #(
  parameter int unsigned N   = 512,
  parameter int unsigned Q   = 12289,
  parameter int unsigned GEN = 11,
  localparam int unsigned CW = $clog2(Q)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [CW-1:0] a_coef,
  input  logic [CW-1:0] b_coef,
  output logic          out_valid,
  output logic [CW-1:0] out_coef,
  output logic          done
);
  import ncm_pkg::*;

  localparam int unsigned LOGN = $clog2(N);
  localparam int unsigned PHI  = ncm_pkg::pow_mod(GEN, (Q - 1) / (2 * N), Q);
  localparam int unsigned NINV = ncm_pkg::pow_mod(N, Q - 2, Q);
  localparam logic [CW-1:0]   NINV_C   = CW'(NINV);
  localparam logic [LOGN-1:0] LAST_CNT = '1;

  function automatic logic [CW-1:0] mmul(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return CW'(ncm_pkg::mod_mul(32'(a), 32'(b), Q));
  endfunction

  phase_t          phase;
  logic [LOGN-1:0] cnt, bf_i0, bf_i1;
  logic [LOGN:0]   tw_exp, rom_addr;
  logic [CW-1:0]   rom_val, rd_a, rd_b, wdat_a, wdat_b;

  // Named internal events.
  logic ld_fire, fwd_fire, inv_fire, pm_fire, out_fire, out_last;
  assign ld_fire  = (phase == PH_LOAD) && in_valid;
  assign fwd_fire = (phase == PH_FWD);
  assign inv_fire = (phase == PH_INV);
  assign pm_fire  = (phase == PH_PMUL);
  assign out_fire = (phase == PH_OUT);
  assign out_last = out_fire && (cnt == LAST_CNT);

  ncm_ctrl #(.N(N)) u_ctrl (
    .clk, .rst_n, .start, .in_valid,
    .phase, .cnt, .bf_i0, .bf_i1, .tw_exp
  );

  always_comb begin
    unique case (phase)
      PH_LOAD:        rom_addr = {1'b0, cnt};
      PH_FWD, PH_INV: rom_addr = tw_exp;
      PH_OUT:         rom_addr = (LOGN+1)'(0) - {1'b0, cnt};
      default:        rom_addr = '0;
    endcase
  end

  ncm_rom #(.N(N), .Q(Q), .PHI(PHI)) u_rom (.addr(rom_addr), .val(rom_val));

  assign wdat_a = ld_fire ? mmul(a_coef, rom_val) : mmul(mmul(rd_a, rd_b), NINV_C);
  assign wdat_b = mmul(b_coef, rom_val);

  ncm_engine #(.N(N), .Q(Q)) u_eng_a (
    .clk, .rst_n,
    .wr_en(ld_fire || pm_fire), .wr_addr(cnt), .wr_data(wdat_a),
    .bf_en(fwd_fire || inv_fire), .bf_inv(inv_fire),
    .bf_i0, .bf_i1, .bf_w(rom_val),
    .rd_addr(cnt), .rd_data(rd_a)
  );

  ncm_engine #(.N(N), .Q(Q)) u_eng_b (
    .clk, .rst_n,
    .wr_en(ld_fire), .wr_addr(cnt), .wr_data(wdat_b),
    .bf_en(fwd_fire), .bf_inv(1'b0),
    .bf_i0, .bf_i1, .bf_w(rom_val),
    .rd_addr(cnt), .rd_data(rd_b)
  );

  logic last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_coef  <= '0;
      last_q    <= 1'b0;
      done      <= 1'b0;
    end else begin
      out_valid <= out_fire;
      out_coef  <= out_fire ? mmul(rd_a, rom_val) : '0;
      last_q    <= out_last;
      done      <= last_q;
    end
  end

  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |-> (32'(a_coef) < Q) && (32'(b_coef) < Q));
  p_out_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_coef) < Q));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid) && !out_valid));
  p_out_only_after_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(phase) == PH_OUT));
endmodule

// File: tb/tb_negacyc_mult.sv
module tb_negacyc_mult;
  localparam int N     = 512;
  localparam int Q     = 12289;
  localparam int CW    = $clog2(Q);
  localparam int LAT   = 1 + 2 * N + $clog2(N) * N;
  localparam int LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          in_valid = 1'b0;
  logic [CW-1:0] a_coef = '0;
  logic [CW-1:0] b_coef = '0;
  logic          out_valid;
  logic [CW-1:0] out_coef;
  logic          done;

  negacyc_mult dut (
    .clk, .rst_n, .start, .in_valid, .a_coef, .b_coef,
    .out_valid, .out_coef, .done
  );

  always #4 clk = ~clk;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int done_cnt = 0;
  int start_edge = 0;
  bit lat_on = 0;
  int exp_q[$];
  int a_v[N];
  int b_v[N];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == LIMIT) begin
      total++;
      fails++;
      $display("FAIL R3 watchdog: act=%0d exp<%0d cycles", cyc, LIMIT);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every output and watches done framing.
  bit prev_ov = 0;
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (!prev_ov && lat_on) begin
          chk(cyc - start_edge == LAT, "R7 latency", cyc - start_edge, LAT);
          lat_on = 0;
        end
        chk(int'(out_coef) < Q, "R4 range", int'(out_coef), Q - 1);
        if (exp_q.size() == 0) chk(0, "R3 extra output", int'(out_coef), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(out_coef) == e, "R1 coefficient", int'(out_coef), e);
        end
      end
      if (done) begin
        chk(prev_ov && !out_valid, "R5 done placement", {30'd0, prev_ov, out_valid}, 2);
        done_cnt++;
      end
      if (prev_done) chk(!done, "R5 done width", int'(done), 0);
      prev_ov   = out_valid;
      prev_done = done;
    end
  end

  // Driver: builds operands, pushes the schoolbook negacyclic result, streams inputs.
  task automatic run_mult(input int mode, input bit bubbles, input bit junk);
    longint acc[N];
    int want;
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: begin a_v[i] = int'($urandom % Q); b_v[i] = int'($urandom % Q); end
        1: begin a_v[i] = 0; b_v[i] = 0; end
        2: begin a_v[i] = Q - 1; b_v[i] = Q - 1; end
        default: begin a_v[i] = (i == N - 1) ? 1 : 0; b_v[i] = (i == 1) ? 1 : 0; end
      endcase
      acc[i] = 0;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        longint p;
        p = (longint'(a_v[i]) * longint'(b_v[j])) % Q;
        if (i + j < N) acc[i + j] = (acc[i + j] + p) % Q;
        else           acc[i + j - N] = (acc[i + j - N] + Q - p) % Q;
      end
    for (int i = 0; i < N; i++) exp_q.push_back(int'(acc[i]));

    want = done_cnt + 1;
    @(negedge clk);
    start = 1'b1;
    start_edge = cyc + 1;
    lat_on = !bubbles;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; ) begin
      if (bubbles && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        a_coef = CW'(77);
        b_coef = CW'(99);
      end else begin
        in_valid = 1'b1;
        a_coef = CW'(a_v[i]);
        b_coef = CW'(b_v[i]);
        i++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (junk) begin
      // R6 / R2: start and in_valid while transforming must be ignored.
      repeat (20) @(negedge clk);
      start = 1'b1;
      in_valid = 1'b1;
      a_coef = CW'(123);
      b_coef = CW'(456);
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;
    end
    wait (done_cnt == want);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 output count", exp_q.size(), 0);
    repeat (4) begin
      @(negedge clk);
      chk(!out_valid, "R6 no stray run", int'(out_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R8 reset outputs", {30'd0, out_valid, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R8 idle outputs", {30'd0, out_valid, done}, 0);
    run_mult(0, 0, 1);  // R1 R7 R6: random, continuous, junk while busy
    run_mult(1, 0, 0);  // R1: all zero
    run_mult(2, 0, 0);  // R1: all q-1
    run_mult(3, 0, 0);  // R1: x^(n-1) * x wraps to -1
    run_mult(0, 1, 0);  // R2: random with in_valid gaps
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule